// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle Sequencing

This block drives an asynchronous serial line. It sends data frames with 8, 9 or 10 character bits. Each frame has a low start bit and a high stop bit. When parity is enabled, the top character bit carries even or odd parity. Besides data it emits two special characters. A break holds the line low for a length that depends on the format. An idle holds the line high for exactly one frame length. Every bit time starts on a one-cycle `baud_tick` pulse supplied from outside.

Words enter through a one-entry buffer with a valid/ready handshake. `s_ready` is high only while the buffer is empty. A word is taken on a cycle where `s_valid` and `s_ready` are both high. A producer facing a low `s_ready` must keep `s_valid` and `s_data` steady until the transfer happens. At each frame boundary the block picks the next character in a fixed priority order: the post-break mark bit, then a break, then a queued idle, then buffered data. In card mode no break or idle is ever produced.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset `tx_line` is 1, `s_ready` is 1 and `tx_empty` is 1.
- R2: A data frame is sent least significant bit first and has C+2 bit times: a 0 start bit, C character bits, then a 1 stop bit. C is 8, 9 or 10 for `fmt_sel` values 0, 1 and 2 (3 behaves as 2). With `par_en` set, character bit C-1 is replaced by parity over `s_data[C-2:0]`; the parity is even, or odd when `par_odd` is 1.
- R3: `tx_line` changes only on the clock edge where `baud_tick` is high; each tick starts one bit time.
- R4: The input buffer holds one word. After an accepted transfer `s_ready` stays low until the word is loaded into the shifter.
- R5: A break is all zeros. Its length in bit times is set by `brk_ext`, the format and parity:
  - `brk_ext`=0: 10 for the 8-bit format, 11 for the 9-bit format, 11 for the 10-bit format without parity, 12 for the 10-bit format with parity.
  - `brk_ext`=1: 13 for the 8-bit format, 14 for the 9-bit and 10-bit formats.
- R6: While `brk_req` stays high, breaks follow one another with no gap. Once it falls, the current break completes and then at least one bit time of logic 1 follows.
- R7: A break requested during a frame starts after that frame's stop bit. It goes ahead of a word already held in the buffer, and that word is sent after the post-break mark bit.
- R8: After `tx_en` rises, one idle character (C+2 bit times of logic 1) is sent before any data.
- R9: If `tx_en` falls during a frame, the frame completes. The line then stays at 1 and a buffered word stays held.
- R10: Lowering and raising `tx_en` during a frame queues one idle character behind that frame, ahead of buffered data.
- R11: With `card_mode` high, `brk_req` and rising edges of `tx_en` produce no break and no idle; data frames still go out.
- R12: `tx_empty` is 1 exactly when the shifter owes no further bit time and the buffer is empty; whenever it is 1, `tx_line` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse starting each bit time |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Request break characters while high |
| brk_ext | input | 1 | Select extended break lengths |
| fmt_sel | input | 2 | Character size: 0=8, 1=9, 2/3=10 bits |
| par_en | input | 1 | Parity in top character bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| card_mode | input | 1 | Suppress break and idle characters |
| s_valid | input | 1 | Input word valid |
| s_data | input | 10 | Input word, LSB sent first |
| s_ready | output | 1 | Buffer can take a word |
| tx_line | output | 1 | Serial output, idles at 1 |
| tx_empty | output | 1 | Shifter and buffer both empty |

## Verification
The key collision is a break request and a buffered data word both waiting at the same frame boundary. A related case is an enable toggle that queues an idle while a word sits in the buffer. The bench provokes both. It pushes a second word and raises `brk_req` (or pulses `tx_en` low) while the first frame is still shifting. It then compares the whole bit stream, one sample per baud tick, against a sequence built from the requirements: the end of the first frame, then the break and its mark bit (or the idle), then the held word. It also confirms that `s_ready` stays low while the word waits.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  // Character size from the format select: 0 -> 8, 1 -> 9, otherwise 10.
  function automatic int unsigned char_bits(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return 8;
      2'd1:    return 9;
      default: return 10;
    endcase
  endfunction

  // Break length in bit times.
  function automatic int unsigned brk_bits(input logic [1:0] fmt,
                                           input logic ext,
                                           input logic pe);
    if (ext) return (fmt == 2'd0) ? 13 : 14;
    case (fmt)
      2'd0:    return 10;
      2'd1:    return 11;
      default: return pe ? 12 : 11;
    endcase
  endfunction

endpackage

// File: rtl/uart_brk_buf.sv
module uart_brk_buf #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  input  logic         take,
  output logic [W-1:0] word,
  output logic         full
);
  assign s_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (s_valid && !full) begin
      full <= 1'b1;
      word <= s_data;
    end
  end
endmodule

// File: rtl/uart_brk_framer.sv
module uart_brk_framer
  import uart_brk_pkg::*;
#(
  parameter int MAXC = 10,
  parameter int FW   = MAXC + 2,
  parameter int LW   = 4
) (
  input  logic [1:0]      fmt,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            brk_ext,
  input  logic [MAXC-1:0] data,
  output logic [FW-1:0]   frame,
  output logic [LW-1:0]   frm_len,
  output logic [LW-1:0]   brk_len
);
  int unsigned c;
  logic        par;

  always_comb begin
    c   = char_bits(fmt);
    par = par_odd;
    for (int i = 0; i < MAXC; i++)
      if (i + 1 < c) par = par ^ data[i];
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAXC; i++) begin
      if (i < c) frame[i+1] = (par_en && (i + 1 == c)) ? par : data[i];
    end
    frm_len = LW'(c + 2);
    brk_len = LW'(brk_bits(fmt, brk_ext, par_en));
  end
endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift #(
  parameter int FW = 12,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          card,
  input  logic          brk_req,
  input  logic          idle_pend,
  input  logic          buf_full,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] frm_len,
  input  logic [LW-1:0] brk_len,
  output logic          line,
  output logic          take,
  output logic          idle_ack,
  output logic          sh_empty
);
  typedef enum logic [2:0] {PICK_NONE, PICK_MARK, PICK_BRK, PICK_IDLE, PICK_DATA} pick_e;

  logic [FW-1:0] sh;
  logic [LW-1:0] cnt;
  logic          fill_q, tail_q, bound, allow_brk;
  pick_e         pick;

  assign bound     = tick && (cnt <= LW'(1));
  assign allow_brk = brk_req && tx_en && !card;
  assign sh_empty  = (cnt == '0);

  always_comb begin
    pick = PICK_NONE;
    if (tail_q && !allow_brk)               pick = PICK_MARK;
    else if (allow_brk)                     pick = PICK_BRK;
    else if (idle_pend && tx_en && !card)   pick = PICK_IDLE;
    else if (buf_full && tx_en)             pick = PICK_DATA;
  end

  assign take     = bound && (pick == PICK_DATA);
  assign idle_ack = bound && (pick == PICK_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      cnt    <= '0;
      fill_q <= 1'b1;
      tail_q <= 1'b0;
      line   <= 1'b1;
    end else if (bound) begin
      case (pick)
        PICK_MARK: begin
          line <= 1'b1; cnt <= LW'(1); tail_q <= 1'b0; fill_q <= 1'b1; sh <= '1;
        end
        PICK_BRK: begin
          line <= 1'b0; cnt <= brk_len; tail_q <= 1'b1; fill_q <= 1'b0; sh <= '0;
        end
        PICK_IDLE: begin
          line <= 1'b1; cnt <= frm_len; fill_q <= 1'b1; sh <= '1;
        end
        PICK_DATA: begin
          line <= frame[0]; cnt <= frm_len; fill_q <= 1'b1;
          sh   <= {1'b1, frame[FW-1:1]};
        end
        default: begin
          line <= 1'b1; cnt <= '0; tail_q <= 1'b0; fill_q <= 1'b1; sh <= '1;
        end
      endcase
    end else if (tick) begin
      line <= sh[0];
      sh   <= {fill_q, sh[FW-1:1]};
      cnt  <= cnt - LW'(1);
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int MAXC    = 10,
  parameter int MAX_BRK = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            baud_tick,
  input  logic            tx_en,
  input  logic            brk_req,
  input  logic            brk_ext,
  input  logic [1:0]      fmt_sel,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            card_mode,
  input  logic            s_valid,
  input  logic [MAXC-1:0] s_data,
  output logic            s_ready,
  output logic            tx_line,
  output logic            tx_empty
);
  localparam int FW = MAXC + 2;
  localparam int LW = $clog2(MAX_BRK + 1);

  logic [MAXC-1:0] word;
  logic            buf_full, take, idle_ack, sh_empty;
  logic            en_q, idle_q;
  logic [FW-1:0]   frame;
  logic [LW-1:0]   frm_len, brk_len;

  uart_brk_buf #(.W(MAXC)) u_buf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .take(take), .word(word), .full(buf_full)
  );

  uart_brk_framer #(.MAXC(MAXC), .FW(FW), .LW(LW)) u_framer (
    .fmt(fmt_sel), .par_en(par_en), .par_odd(par_odd), .brk_ext(brk_ext),
    .data(word), .frame(frame), .frm_len(frm_len), .brk_len(brk_len)
  );

  uart_brk_shift #(.FW(FW), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_en(tx_en),
    .card(card_mode), .brk_req(brk_req), .idle_pend(idle_q),
    .buf_full(buf_full), .frame(frame), .frm_len(frm_len),
    .brk_len(brk_len), .line(tx_line), .take(take),
    .idle_ack(idle_ack), .sh_empty(sh_empty)
  );

  // An enable rising edge queues one idle character (preamble or re-enable).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (card_mode)               idle_q <= 1'b0;
      else if (tx_en && !en_q)     idle_q <= 1'b1;
      else if (idle_ack)           idle_q <= 1'b0;
    end
  end

  assign tx_empty = sh_empty && !buf_full;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx_en,
  input logic card_mode,
  input logic s_valid,
  input logic s_ready,
  input logic tx_line,
  input logic tx_empty
);
  p_hold_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line));

  p_one_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_empty_mark_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_line);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_empty) |=> tx_line);

  p_card_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (card_mode && tx_empty) |=> tx_line);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
  .card_mode(card_mode), .s_valid(s_valid), .s_ready(s_ready),
  .tx_line(tx_line), .tx_empty(tx_empty)
);

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, tx_en = 1'b0;
  logic brk_req = 1'b0, brk_ext = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic card_mode = 1'b0, s_valid = 1'b0;
  logic [1:0] fmt_sel = 2'd0;
  logic [9:0] s_data = '0;
  logic s_ready, tx_line, tx_empty;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_brk_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_req(brk_req), .brk_ext(brk_ext), .fmt_sel(fmt_sel),
    .par_en(par_en), .par_odd(par_odd), .card_mode(card_mode),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tx_line(tx_line), .tx_empty(tx_empty)
  );

  // {fmt, parity enable, odd, data}
  localparam logic [13:0] VEC [0:6] = '{
    {2'd0, 1'b0, 1'b0, 10'h0A5}, {2'd0, 1'b1, 1'b0, 10'h053},
    {2'd0, 1'b1, 1'b1, 10'h07F}, {2'd1, 1'b0, 1'b0, 10'h1C3},
    {2'd1, 1'b1, 1'b1, 10'h0F0}, {2'd2, 1'b0, 1'b0, 10'h2B6},
    {2'd2, 1'b1, 1'b0, 10'h155}
  };
  // {fmt, ext, parity enable, expected break length}
  localparam logic [8:0] BRK [0:5] = '{
    {2'd0, 1'b0, 1'b0, 5'd10}, {2'd1, 1'b0, 1'b0, 5'd11},
    {2'd2, 1'b0, 1'b0, 5'd11}, {2'd2, 1'b0, 1'b1, 5'd12},
    {2'd0, 1'b1, 1'b0, 5'd13}, {2'd1, 1'b1, 1'b0, 5'd14}
  };

  function automatic int clen(input logic [1:0] f);
    return (f == 2'd0) ? 8 : (f == 2'd1) ? 9 : 10;
  endfunction

  function automatic logic [63:0] efrm(input logic [1:0] f, input logic pe,
                                       input logic po, input logic [9:0] d);
    logic [63:0] r;
    logic p;
    int c;
    c = clen(f);
    r = '1;
    r[0] = 1'b0;
    p = po;
    for (int i = 0; i < c - 1; i++) p = p ^ d[i];
    for (int i = 0; i < c; i++) r[i+1] = (pe && i == c - 1) ? p : d[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick_bit(output logic v);
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    v = tx_line;
  endtask

  task automatic expect_stream(input logic [63:0] pat, input int n, input string tag);
    logic v;
    int bad;
    logic got;
    bad = -1;
    got = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick_bit(v);
      if (v !== pat[i] && bad < 0) begin bad = i; got = v; end
    end
    check(bad < 0, tag, {31'd0, got}, bad < 0 ? 32'd0 : {31'd0, pat[bad]});
    if (bad >= 0) $display("  (mismatch in %s at bit %0d)", tag, bad);
  endtask

  task automatic push(input logic [9:0] d);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d;
    @(negedge clk) s_valid = 1'b0;
  endtask

  task automatic set_fmt(input logic [1:0] f, input logic pe, input logic po);
    fmt_sel = f; par_en = pe; par_odd = po;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] f1, f2;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1, "R1 line", tx_line, 1);
    check(s_ready === 1'b1, "R1 ready", s_ready, 1);
    check(tx_empty === 1'b1, "R1 empty", tx_empty, 1);
    rst_n = 1'b1;

    // R8: preamble idle precedes first frame
    set_fmt(2'd0, 1'b0, 1'b0);
    @(negedge clk) tx_en = 1'b1;
    push(10'h03C);
    check(s_ready === 1'b0, "R4 held", s_ready, 0);
    f1 = efrm(2'd0, 0, 0, 10'h03C);
    expect_stream({f1[53:0], 10'h3FF}, 20, "R8 preamble+frame");
    check(tx_empty === 1'b0, "R12 busy on stop bit", tx_empty, 0);
    expect_stream(64'h1, 1, "R12 idle bit");
    check(tx_empty === 1'b1, "R12 empty", tx_empty, 1);

    // R2 / R3: vector table of frame formats
    for (int k = 0; k < 7; k++) begin
      set_fmt(VEC[k][13:12], VEC[k][11], VEC[k][10]);
      push(VEC[k][9:0]);
      f1 = efrm(VEC[k][13:12], VEC[k][11], VEC[k][10], VEC[k][9:0]);
      expect_stream(f1, 1, "R2 start bit");
      repeat (6) @(negedge clk);
      check(tx_line === 1'b0, "R3 no tick hold", tx_line, 0);
      expect_stream(f1 >> 1, clen(VEC[k][13:12]) + 1, "R2 frame");
    end
    expect_stream(64'h1, 1, "R2 settle");

    // R5 / R6: break lengths followed by mark bit
    for (int k = 0; k < 6; k++) begin
      set_fmt(BRK[k][8:7], BRK[k][5], 1'b0);
      brk_ext = BRK[k][6];
      @(negedge clk) brk_req = 1'b1;
      expect_stream(64'h0, int'(BRK[k][4:0]), "R5 break zeros");
      brk_req = 1'b0;
      expect_stream(64'h1, 1, "R6 mark after break");
    end
    brk_ext = 1'b0;
    set_fmt(2'd0, 1'b0, 1'b0);
    expect_stream(64'h1, 1, "R6 idle");

    // R6: back-to-back breaks
    brk_req = 1'b1;
    expect_stream(64'h0, 20, "R6 back-to-back");
    brk_req = 1'b0;
    expect_stream(64'h3, 2, "R6 release mark");

    // R7: break after current frame, ahead of buffered word
    f1 = efrm(2'd0, 0, 0, 10'h0C9);
    f2 = efrm(2'd0, 0, 0, 10'h036);
    push(10'h0C9);
    expect_stream(f1, 3, "R7 frame head");
    push(10'h036);
    brk_req = 1'b1;
    expect_stream(f1 >> 3, 7, "R7 frame tail");
    expect_stream(64'h0, 10, "R7 break");
    check(s_ready === 1'b0, "R7 word held", s_ready, 0);
    brk_req = 1'b0;
    expect_stream({f2[62:0], 1'b1}, 11, "R7 mark then word");

    // R9: enable drop mid-frame
    push(10'h11E);
    f1 = efrm(2'd0, 0, 0, 10'h11E);
    expect_stream(f1, 2, "R9 head");
    tx_en = 1'b0;
    expect_stream(f1 >> 2, 8, "R9 frame completes");
    push(10'h081);
    expect_stream(64'hFFF, 12, "R9 line stays high");
    check(s_ready === 1'b0, "R9 word held", s_ready, 0);
    tx_en = 1'b1;
    f2 = efrm(2'd0, 0, 0, 10'h081);
    expect_stream({f2[53:0], 10'h3FF}, 20, "R8 re-enable preamble");

    // R10: enable toggle mid-frame queues idle
    push(10'h0E7);
    f1 = efrm(2'd0, 0, 0, 10'h0E7);
    expect_stream(f1, 2, "R10 head");
    push(10'h018);
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk) tx_en = 1'b1;
    f2 = efrm(2'd0, 0, 0, 10'h018);
    expect_stream(f1 >> 2, 8, "R10 frame completes");
    expect_stream({f2[53:0], 10'h3FF}, 20, "R10 idle then word");

    // R11: card mode suppresses break and idle
    card_mode = 1'b1;
    brk_req = 1'b1;
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk) tx_en = 1'b1;
    expect_stream(64'hFFFF, 15, "R11 no break or idle");
    push(10'h0A9);
    f1 = efrm(2'd0, 0, 0, 10'h0A9);
    expect_stream(f1, 10, "R11 data still sent");
    brk_req = 1'b0;
    card_mode = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule